// File: doc/BRIEF.md
# Distributed Multiprocessor Bus Arbiter Node

This block is the arbitration logic held by one node of a group of up to eight processors that share a single external bus. Every node holds an identical copy. Each node pulls down one active-low request line, the one picked by its node number. It watches all eight request lines and a few shared open-drain lines, and from them it tracks the same bus owner as every other node. The node reports when it is the master. It grants the bus to its own local port, and it drives the shared lines that tell the other nodes about its own urgency and lock state.

A local access falls into one of three classes: core (highest), high-priority DMA, or normal DMA. A node that has a core access pending pulls the core-priority line. A node with a high-priority DMA access pulls the DMA-priority line. While a line of a higher class than its own is active, a node withdraws its request. Only requests of the highest class in play then take part in the next decision. Ownership moves at transaction boundaries in round-robin order after the current owner. While the shared lock line is active, ownership stays where it is. Every shared input passes through the same synchronizer depth in every node, so all nodes see the same values in the same cycle.

Top module: `mpbus_arb_node`

## Requirements
- R1: The node number is captured from `node_id` on every clock edge while `rst_n` is low. A change of `node_id` after reset has no effect on `is_master`.
- R2: `req_n_out` is low exactly when `loc_req` is high and no synchronized priority line of a higher class is active. The local class is core when `loc_core`=1, high-priority DMA when `loc_core`=0 and `loc_hpdma`=1, and normal otherwise. Core outranks high-priority DMA, which outranks normal.
- R3: `core_pri_drv` is high when `loc_req` and `loc_core` are both high. `dma_pri_drv` is high when `loc_req` and `loc_hpdma` are high and `loc_core` is low. The two are never high together.
- R4: After reset the owner is node 0. `is_master` is high exactly when the owner equals the captured node number. The request line and all drives are inactive while no local request is pending.
- R5: At a synchronized boundary with the lock line inactive and at least one request line low, the new owner is the first low line found by scanning upward from owner+1 with wrap. The current owner is considered last.
- R6: A boundary at which no request line is low leaves the owner unchanged.
- R7: The owner changes only in the cycle after a synchronized boundary sample. Requests alone never move it.
- R8: A boundary seen while the synchronized lock line is low leaves the owner unchanged.
- R9: `lock_drv` is high only while the node is master and `loc_lock` is high.
- R10: `local_grant` is high exactly when the node is master and `loc_req` is high.
- R11: Each shared input (request lines, both priority lines, lock line, boundary) reaches the decision logic after SYNC_STAGES clock edges. An ownership change appears one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset; node number is captured while low |
| node_id | input | ID_W | Node number, static during operation |
| loc_req | input | 1 | Local port wants the bus |
| loc_core | input | 1 | Local access is a core access |
| loc_hpdma | input | 1 | Local access is a high-priority DMA access |
| loc_lock | input | 1 | Local port wants to hold the bus |
| req_n_in | input | NODES | Sampled request lines of all nodes, active low |
| core_pri_n_in | input | 1 | Sampled core-priority line, active low |
| dma_pri_n_in | input | 1 | Sampled DMA-priority line, active low |
| lock_n_in | input | 1 | Sampled bus-lock line, active low |
| boundary_in | input | 1 | Transaction boundary on the shared bus, one-cycle pulse |
| req_n_out | output | 1 | This node's request line level |
| core_pri_drv | output | 1 | Pull-down enable for the core-priority line |
| dma_pri_drv | output | 1 | Pull-down enable for the DMA-priority line |
| lock_drv | output | 1 | Pull-down enable for the bus-lock line |
| is_master | output | 1 | This node currently owns the bus |
| local_grant | output | 1 | Bus granted to the local port |

## Verification
The bench builds eight copies with the default NODES=8 and SYNC_STAGES=2. Every copy gets its own number, and all copies share the same sampled bus lines. The owner can therefore be read from the master flags alone, and the bench checks that exactly one flag is set after each decision. With eight nodes, the round-robin scan wraps past node 7, so every rotation and wrap order can be reached. With two synchronizer stages, the latency of R11 is long enough to catch an early or late update in the cycle between the input change and the output change.

// File: rtl/mpbus_arb_pkg.sv
package mpbus_arb_pkg;
   // Access classes, ordered so that a larger value outranks a smaller one.
   typedef enum logic [1:0] {
      CLS_NORM  = 2'd0,
      CLS_HPDMA = 2'd1,
      CLS_CORE  = 2'd2
   } acc_cls_e;
endpackage

// File: rtl/mpbus_arb_sync.sv
module mpbus_arb_sync #(
   parameter int          W       = 8,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mpbus_arb_rr.sv
module mpbus_arb_rr #(
   parameter int NODES = 8,
   localparam int ID_W = $clog2(NODES)
) (
   input  logic [ID_W-1:0]  owner,
   input  logic [NODES-1:0] req,
   output logic             any,
   output logic [ID_W-1:0]  next
);
   // Scan upward from owner+1 with wrap; k == NODES lands on the owner itself.
   always_comb begin
      logic             found;
      logic [ID_W-1:0]  idx;
      any   = |req;
      next  = owner;
      found = 1'b0;
      for (int k = 1; k <= NODES; k++) begin
         idx = owner + ID_W'(k);
         if (!found && req[idx]) begin
            next  = idx;
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/mpbus_arb_req.sv
module mpbus_arb_req
   import mpbus_arb_pkg::*;
(
   input  logic loc_req,
   input  logic loc_core,
   input  logic loc_hpdma,
   input  logic core_line_act,
   input  logic dma_line_act,
   output logic req_act,
   output logic core_drv,
   output logic dma_drv
);
   acc_cls_e own_cls, top_cls;

   always_comb begin
      if (loc_core)       own_cls = CLS_CORE;
      else if (loc_hpdma) own_cls = CLS_HPDMA;
      else                own_cls = CLS_NORM;

      if (core_line_act)     top_cls = CLS_CORE;
      else if (dma_line_act) top_cls = CLS_HPDMA;
      else                   top_cls = CLS_NORM;
   end

   assign req_act  = loc_req && (own_cls >= top_cls);
   assign core_drv = loc_req && (own_cls == CLS_CORE);
   assign dma_drv  = loc_req && (own_cls == CLS_HPDMA);
endmodule

// File: rtl/mpbus_arb_node.sv
module mpbus_arb_node #(
   parameter int NODES       = 8,
   parameter int SYNC_STAGES = 2,
   localparam int ID_W = $clog2(NODES),
   localparam int SW   = NODES + 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ID_W-1:0]  node_id,
   input  logic             loc_req,
   input  logic             loc_core,
   input  logic             loc_hpdma,
   input  logic             loc_lock,
   input  logic [NODES-1:0] req_n_in,
   input  logic             core_pri_n_in,
   input  logic             dma_pri_n_in,
   input  logic             lock_n_in,
   input  logic             boundary_in,
   output logic             req_n_out,
   output logic             core_pri_drv,
   output logic             dma_pri_drv,
   output logic             lock_drv,
   output logic             is_master,
   output logic             local_grant
);
   generate
      if (NODES < 2 || (NODES & (NODES - 1)) != 0) begin : g_bad_nodes
         $error("NODES must be a power of two of at least 2");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   // Synchronized view of the shared bus lines, identical in every node.
   logic [SW-1:0]    sh_raw, sh_s;
   logic [NODES-1:0] req_s_n;
   logic             core_s_n, dma_s_n, lock_s_n, bnd_s;

   assign sh_raw = {boundary_in, lock_n_in, dma_pri_n_in, core_pri_n_in, req_n_in};

   mpbus_arb_sync #(
      .W      (SW),
      .STAGES (SYNC_STAGES),
      .RST_VAL({1'b0, {(SW-1){1'b1}}})
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (sh_raw),
      .q    (sh_s)
   );

   assign {bnd_s, lock_s_n, dma_s_n, core_s_n, req_s_n} = sh_s;

   // Node number is captured only while reset is held.
   logic [ID_W-1:0] id_q;
   always_ff @(posedge clk) begin
      if (!rst_n) id_q <= node_id;
   end

   // Ownership tracking.
   logic [ID_W-1:0] owner_q, rr_next;
   logic            rr_any;

   mpbus_arb_rr #(.NODES(NODES)) u_rr (
      .owner(owner_q),
      .req  (~req_s_n),
      .any  (rr_any),
      .next (rr_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           owner_q <= '0;
      else if (bnd_s && lock_s_n && rr_any) owner_q <= rr_next;
   end

   // Request line and priority drives.
   logic req_act;

   mpbus_arb_req u_req (
      .loc_req      (loc_req),
      .loc_core     (loc_core),
      .loc_hpdma    (loc_hpdma),
      .core_line_act(!core_s_n),
      .dma_line_act (!dma_s_n),
      .req_act      (req_act),
      .core_drv     (core_pri_drv),
      .dma_drv      (dma_pri_drv)
   );

   assign req_n_out   = !req_act;
   assign is_master   = (owner_q == id_q);
   assign local_grant = is_master && loc_req;
   assign lock_drv    = is_master && loc_lock;
endmodule

// File: rtl/mpbus_arb_node_chk.sv
module mpbus_arb_node_chk #(
   parameter int NODES = 8,
   localparam int ID_W = $clog2(NODES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bnd_s,
   input logic             lock_s_n,
   input logic             core_s_n,
   input logic [NODES-1:0] req_s_n,
   input logic [ID_W-1:0]  owner_q,
   input logic [ID_W-1:0]  id_q,
   input logic             loc_core,
   input logic             req_n_out,
   input logic             core_pri_drv,
   input logic             dma_pri_drv,
   input logic             local_grant,
   input logic             is_master,
   input logic             lock_drv
);
   p_id_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(id_q));

   p_core_withdraw_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_s_n && !loc_core) |-> req_n_out);

   p_drv_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(core_pri_drv && dma_pri_drv));

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd_s && (&req_s_n)) |=> $stable(owner_q));

   p_move_at_bnd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q != $past(owner_q)) |-> $past(bnd_s));

   p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd_s && !lock_s_n) |=> $stable(owner_q));

   p_lock_drv_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lock_drv |-> is_master);

   p_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
      local_grant |-> is_master);
endmodule

bind mpbus_arb_node mpbus_arb_node_chk #(.NODES(NODES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bnd_s       (bnd_s),
   .lock_s_n    (lock_s_n),
   .core_s_n    (core_s_n),
   .req_s_n     (req_s_n),
   .owner_q     (owner_q),
   .id_q        (id_q),
   .loc_core    (loc_core),
   .req_n_out   (req_n_out),
   .core_pri_drv(core_pri_drv),
   .dma_pri_drv (dma_pri_drv),
   .local_grant (local_grant),
   .is_master   (is_master),
   .lock_drv    (lock_drv)
);

// File: tb/tb_mpbus_arb_node.sv
module tb_mpbus_arb_node;
   localparam int N = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic         rst_n;
   logic [2:0]   id_drv [N];
   logic         loc_req, loc_core, loc_hpdma, loc_lock;
   logic [N-1:0] req_n_bus;
   logic         core_n, dma_n, lock_n, bnd;

   logic [N-1:0] reqo_v, cdrv_v, ddrv_v, lockd_v, master_v, grant_v;

   for (genvar i = 0; i < N; i++) begin : g_node
      mpbus_arb_node dut (
         .clk          (clk),
         .rst_n        (rst_n),
         .node_id      (id_drv[i]),
         .loc_req      (loc_req),
         .loc_core     (loc_core),
         .loc_hpdma    (loc_hpdma),
         .loc_lock     (loc_lock),
         .req_n_in     (req_n_bus),
         .core_pri_n_in(core_n),
         .dma_pri_n_in (dma_n),
         .lock_n_in    (lock_n),
         .boundary_in  (bnd),
         .req_n_out    (reqo_v[i]),
         .core_pri_drv (cdrv_v[i]),
         .dma_pri_drv  (ddrv_v[i]),
         .lock_drv     (lockd_v[i]),
         .is_master    (master_v[i]),
         .local_grant  (grant_v[i])
      );
   end

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic decide();
      step(1);
      bnd = 1'b1;
      step(1);
      bnd = 1'b0;
      step(5);
   endtask

   // Row: {requesting nodes (active high), lock active, expected owner}
   localparam logic [11:0] VEC [10] = '{
      {8'b0000_0000, 1'b0, 3'd0},   // R6 no request
      {8'b0001_0100, 1'b0, 3'd2},   // R5
      {8'b0001_0100, 1'b0, 3'd4},   // R5
      {8'b0001_0100, 1'b0, 3'd2},   // R5 wrap
      {8'b0000_0100, 1'b0, 3'd2},   // R5 owner alone
      {8'b1000_0001, 1'b1, 3'd2},   // R8 lock
      {8'b1000_0001, 1'b0, 3'd7},   // R5
      {8'b1000_0001, 1'b0, 3'd0},   // R5 wrap
      {8'b1111_1111, 1'b0, 3'd1},   // R5 all
      {8'b0100_0000, 1'b0, 3'd6}    // R5
   };

   initial begin
      #(4 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      for (int i = 0; i < N; i++) id_drv[i] = 3'(i);
      loc_req = 0; loc_core = 0; loc_hpdma = 0; loc_lock = 0;
      req_n_bus = '1; core_n = 1; dma_n = 1; lock_n = 1; bnd = 0;
      step(4);
      rst_n = 1'b1;
      step(1);

      chk("R4 owner after reset", master_v, 8'b0000_0001);
      chk("R4 request idle", reqo_v, 8'hFF);
      chk("R4 drives idle", cdrv_v | ddrv_v | lockd_v | grant_v, 8'h00);

      // R1: scramble node numbers after reset; latched values must rule.
      for (int i = 0; i < N; i++) id_drv[i] = 3'(N - 1 - i);
      step(3);
      chk("R1 id change ignored", master_v, 8'b0000_0001);

      for (int r = 0; r < 10; r++) begin
         req_n_bus = ~VEC[r][11:4];
         lock_n    = ~VEC[r][3];
         decide();
         chk($sformatf("R5 R6 R8 row %0d", r), master_v, N'(1) << VEC[r][2:0]);
      end
      lock_n = 1'b1;

      // R7: requests without a boundary never move the owner.
      req_n_bus = ~8'b0000_1000;
      step(10);
      chk("R7 no boundary hold", master_v, 8'b0100_0000);
      decide();
      chk("R5 move to 3", master_v, 8'b0000_1000);
      req_n_bus = '1;

      // R2 R3 R10: normal class request.
      loc_req = 1'b1;
      step(3);
      chk("R2 normal request", reqo_v, 8'h00);
      chk("R3 no priority drive", cdrv_v | ddrv_v, 8'h00);
      chk("R10 grant at owner", grant_v, 8'b0000_1000);

      // R11: DMA line needs two edges to reach the node.
      dma_n = 1'b0;
      step(1);
      chk("R11 not yet synced", reqo_v, 8'h00);
      step(2);
      chk("R2 normal withdrawn by dma line", reqo_v, 8'hFF);

      loc_hpdma = 1'b1;
      step(1);
      chk("R2 hpdma survives dma line", reqo_v, 8'h00);
      chk("R3 dma drive", ddrv_v, 8'hFF);
      chk("R3 core drive off", cdrv_v, 8'h00);

      core_n = 1'b0;
      step(3);
      chk("R2 hpdma withdrawn by core line", reqo_v, 8'hFF);

      loc_core = 1'b1;
      step(1);
      chk("R2 core survives", reqo_v, 8'h00);
      chk("R3 core drive", cdrv_v, 8'hFF);
      chk("R3 dma drive dropped", ddrv_v, 8'h00);

      loc_lock = 1'b1;
      step(1);
      chk("R9 lock drive at owner", lockd_v, 8'b0000_1000);
      loc_lock = 1'b0;
      step(1);
      chk("R9 lock drive released", lockd_v, 8'h00);

      loc_req = 1'b0;
      step(1);
      chk("R10 grant drops", grant_v, 8'h00);
      chk("R3 drives drop", cdrv_v | ddrv_v, 8'h00);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule